// File: doc/BRIEF.md
# Three-Source Bitwise Combiner with Area Fill

This block is the bitwise combining stage of a block-transfer engine. For every word it receives three W-bit sources (two shifted sources A and B plus the destination word C) and an 8-bit function code. The function code works as a truth table over the three source bits. Each result bit is the table entry that the matching bits of A, B and C select.

After the combined word is registered, an optional area-fill pass walks the word from bit 0 upward, carrying one bit along. In exclusive mode the carry toggles on each set bit, and the output follows the carry. In inclusive mode the output keeps every set bit and also sets bits while the carry is high. The carry left after the top bit is presented as a carry-out. The engine can feed this carry-out back in for the next word of the same line, or clear it at the start of a new line. Results appear one clock after the strobe that presents the inputs.

Top module: `blf_logic_fill`

## Requirements
- R1: With no fill enabled, result bit i equals `func_i[{src_a_i[i], src_b_i[i], src_c_i[i]}]`, with A as index bit 2 and C as index bit 0.
- R2: With no fill enabled, `result_o` is the combined word unchanged and `carry_o` equals the seed carry.
- R3: With exclusive fill, processing from bit 0 to bit W-1, carry_k = carry_(k-1) XOR r_k and output bit k = carry_k, where r is the combined word and carry_(-1) is the seed.
- R4: With inclusive fill, output bit k = carry_(k-1) OR r_k, and the carry follows the same XOR recurrence as R3.
- R5: When either fill is enabled, `carry_o` is the carry after bit W-1.
- R6: If both fill enables are set, exclusive fill applies.
- R7: The seed carry is 0 when `line_start_i` is high with the strobe, and `carry_i` otherwise.
- R8: `valid_o` is high in exactly the cycle after each cycle in which `strobe_i` is high.
- R9: After reset, `result_o`, `carry_o` and `valid_o` are 0. Without a strobe, `result_o` and `carry_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Inputs valid, capture this cycle |
| src_a_i | input | W | Source A word |
| src_b_i | input | W | Source B word |
| src_c_i | input | W | Destination word |
| func_i | input | 8 | Minterm truth table |
| xfill_en_i | input | 1 | Exclusive fill enable |
| ifill_en_i | input | 1 | Inclusive fill enable |
| carry_i | input | 1 | Fill carry from previous word |
| line_start_i | input | 1 | First word of a line, seed carry 0 |
| result_o | output | W | Combined and filled word |
| carry_o | output | 1 | Fill carry after top bit |
| valid_o | output | 1 | Result valid |

## Verification
A wrong captured mode or seed shows at the ports in the first cycle after the strobe. The whole fill output is derived from those registers, and a single wrong carry bit inverts every higher bit in exclusive mode. A stale or lost register load shows as a result, carry or valid value that differs from the per-cycle model in that same cycle. Long random runs with chained carries expose carry errors that cross word boundaries.

// File: rtl/blf_pkg.sv
package blf_pkg;
  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_XOR  = 2'd1,
    FILL_OR   = 2'd2
  } fill_mode_e;
endpackage

// File: rtl/blf_minterm.sv
module blf_minterm #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [7:0]   fn_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res_o[i] = fn_i[{a_i[i], b_i[i], c_i[i]}];
  end
endmodule

// File: rtl/blf_fill_chain.sv
module blf_fill_chain
  import blf_pkg::*;
#(
  parameter int W = 8
) (
  input  fill_mode_e   mode_i,
  input  logic         seed_i,
  input  logic [W-1:0] res_i,
  output logic [W-1:0] out_o,
  output logic         carry_o
);
  logic [W:0] cy;
  assign cy[0] = seed_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign cy[i+1] = cy[i] ^ res_i[i];
    always_comb begin
      unique case (mode_i)
        FILL_XOR: out_o[i] = cy[i+1];
        FILL_OR:  out_o[i] = cy[i] | res_i[i];
        default:  out_o[i] = res_i[i];
      endcase
    end
  end

  assign carry_o = (mode_i == FILL_NONE) ? seed_i : cy[W];
endmodule

// File: rtl/blf_logic_fill.sv
module blf_logic_fill
  import blf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] src_a_i,
  input  logic [W-1:0] src_b_i,
  input  logic [W-1:0] src_c_i,
  input  logic [7:0]   func_i,
  input  logic         xfill_en_i,
  input  logic         ifill_en_i,
  input  logic         carry_i,
  input  logic         line_start_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         valid_o
);
  logic [W-1:0] comb_res;
  logic [W-1:0] res_q;
  fill_mode_e   mode_d, mode_q;
  logic         seed_q;
  logic         valid_q;

  blf_minterm #(.W(W)) i_minterm (
    .a_i  (src_a_i),
    .b_i  (src_b_i),
    .c_i  (src_c_i),
    .fn_i (func_i),
    .res_o(comb_res)
  );

  // exclusive fill wins when both are requested
  always_comb begin
    if (xfill_en_i)      mode_d = FILL_XOR;
    else if (ifill_en_i) mode_d = FILL_OR;
    else                 mode_d = FILL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      mode_q  <= FILL_NONE;
      seed_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe_i;
      if (strobe_i) begin
        res_q  <= comb_res;
        mode_q <= mode_d;
        seed_q <= line_start_i ? 1'b0 : carry_i;
      end
    end
  end

  blf_fill_chain #(.W(W)) i_fill (
    .mode_i (mode_q),
    .seed_i (seed_q),
    .res_i  (res_q),
    .out_o  (result_o),
    .carry_o(carry_o)
  );

  assign valid_o = valid_q;

  a_r8_valid_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);
  a_r8_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !valid_o);
  a_r9_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(result_o) && $stable(carry_o)));
  a_r3_xor_top_bit_is_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == FILL_XOR) |-> (result_o[W-1] == carry_o));
  a_r4_or_keeps_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == FILL_OR) |-> ((result_o & res_q) == res_q));
  a_r7_line_start_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && line_start_i && !xfill_en_i && !ifill_en_i) |=> !carry_o);
endmodule

// File: tb/test_blf_logic_fill.sv
module test_blf_logic_fill;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         strobe = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic [7:0]   fn = '0;
  logic         xf = 1'b0, inf = 1'b0, cin = 1'b0, ls = 1'b0;
  logic [W-1:0] result;
  logic         carry, valid;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] exp_res = '0;
  logic         exp_carry = 1'b0;
  logic         exp_valid = 1'b0;

  always #10 clk = ~clk;

  blf_logic_fill #(.W(W)) i_blf_logic_fill (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe),
    .src_a_i(a), .src_b_i(b), .src_c_i(c), .func_i(fn),
    .xfill_en_i(xf), .ifill_en_i(inf), .carry_i(cin), .line_start_i(ls),
    .result_o(result), .carry_o(carry), .valid_o(valid)
  );

  task automatic check(input string tag);
    checks++;
    if (result !== exp_res || carry !== exp_carry || valid !== exp_valid) begin
      failures++;
      $display("FAIL %s: got res=%h carry=%b valid=%b, expected res=%h carry=%b valid=%b",
               tag, result, carry, valid, exp_res, exp_carry, exp_valid);
    end
  endtask

  // behavioural reference for one strobed word
  task automatic model();
    int r[W];
    int cy;
    int idx;
    cy = ls ? 0 : int'(cin);
    for (int i = 0; i < W; i++) begin
      idx = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
      r[i] = int'(fn[idx]);
    end
    for (int i = 0; i < W; i++) begin
      int prev = cy;
      cy = cy ^ r[i];
      if (xf)       exp_res[i] = (cy != 0);
      else if (inf) exp_res[i] = (prev != 0) || (r[i] != 0);
      else          exp_res[i] = (r[i] != 0);
    end
    if (xf || inf) exp_carry = (cy != 0);
    else           exp_carry = ls ? 1'b0 : cin;
  endtask

  // drive at negedge, result visible after posedge, compare at next negedge
  task automatic step(input logic stb, input logic [W-1:0] ia, ib, ic,
                      input logic [7:0] ifn, input logic ix, ii, ic_in, ils);
    string tag;
    strobe = stb; a = ia; b = ib; c = ic; fn = ifn;
    xf = ix; inf = ii; cin = ic_in; ls = ils;
    if (stb) begin
      model();
      exp_valid = 1'b1;
      if (ix && ii)  tag = "R6 R3 R5";
      else if (ix)   tag = "R3 R5";
      else if (ii)   tag = "R4 R5";
      else           tag = "R1 R2";
      if (ils) tag = {tag, " R7"};
      else     tag = {tag, " R7 R8"};
    end else begin
      exp_valid = 1'b0;
      tag = "R8 R9";
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset release");
    // R1: pure minterm selections
    step(1, 8'hA5, 8'h3C, 8'h0F, 8'hF0, 0, 0, 1, 0); // copy A
    step(1, 8'hA5, 8'h3C, 8'h0F, 8'hCC, 0, 0, 0, 0); // copy B
    step(1, 8'hA5, 8'h3C, 8'h0F, 8'h96, 0, 0, 1, 1); // A^B^C
    step(1, 8'hFF, 8'hFF, 8'hFF, 8'h80, 0, 0, 0, 0); // AND
    step(0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0); // R9 hold
    step(0, 8'h55, 8'h55, 8'h55, 8'hFF, 1, 1, 1, 0);
    // R3 exclusive fill
    step(1, 8'h24, 8'h00, 8'h00, 8'hF0, 1, 0, 0, 1);
    step(1, 8'h24, 8'h00, 8'h00, 8'hF0, 1, 0, 1, 0);
    step(1, 8'h81, 8'h00, 8'h00, 8'hF0, 1, 0, 1, 1);
    // R4 inclusive fill
    step(1, 8'h24, 8'h00, 8'h00, 8'hF0, 0, 1, 0, 1);
    step(1, 8'h01, 8'h00, 8'h00, 8'hF0, 0, 1, 1, 0);
    step(1, 8'h00, 8'h00, 8'h00, 8'hF0, 0, 1, 1, 0);
    // R6 both enables
    step(1, 8'h42, 8'h00, 8'h00, 8'hF0, 1, 1, 0, 0);
    step(0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0);
    // random chained run: carry fed back between words
    for (int n = 0; n < 400; n++) begin
      logic s, x, i, l, ci;
      s  = ($urandom_range(0, 3) != 0);
      x  = $urandom_range(0, 2) == 0;
      i  = $urandom_range(0, 2) == 0;
      l  = $urandom_range(0, 4) == 0;
      ci = ($urandom_range(0, 1) == 1) ? carry : 1'($urandom_range(0, 1));
      step(s, W'($urandom), W'($urandom), W'($urandom), 8'($urandom), x, i, ci, l);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule